// File: doc/BRIEF.md
# Pixel PLL Divide-Count Calculator

This block turns a requested pixel clock frequency into the settings a programmable pixel PLL needs. The request is given in units of 10 kHz. The block finds which of four frequency bands holds the request and snaps the request to that band's step size. It then forms one frequency byte from a two-bit band code and a six-bit VCO divide count.

Alongside the byte, the block chooses the post-PLL clock divider. The choice depends on the pixel depth and on whether the graphics engine itself divides the pixel clock.

A request arrives on a valid/ready input. `in_ready` is high whenever the block is idle. A transfer happens on any clock edge where both `in_valid` and `in_ready` are high. After accepting a request, the block drops `in_ready` for exactly one cycle while it computes. On the edge that follows, it updates its outputs, pulses `out_done` for one cycle and raises `in_ready` again. The source may hold `in_valid` high at any time. While `in_ready` is low, the input values are not sampled. The result side has no back-pressure: a result is marked only by the `out_done` pulse, and the outputs hold their values until the next result.

Top module: `pll_divcount_calc`

## Requirements
- R1: Band 0 covers requests 1625..3200 (16.25 to 32.00 MHz) with a step of 25. The count is (4*R - 6500)/100, where R is the rounded request. The frequency byte is {2'b00, count}: the band code sits in bits [7:6] and the count in bits [5:0].
- R2: Band 1 covers 3250..6400 with a step of 50. The count is (2*R - 6500)/100 and the band code is 2'b01.
- R3: Band 2 covers 6500..12800 with a step of 100. The count is (R - 6500)/100 and the band code is 2'b10.
- R4: Band 3 covers 13000..25000 with a step of 200. The count is (R/2 - 6500)/100 and the band code is 2'b11.
- R5: Rounding works in two stages. First the request is truncated to a multiple of the band step. It then moves up by one step if the remainder is at least half the step, using integer halving (12, 25, 50 or 100).
- R6: A request outside all four bands does three things:
  - it sets `out_unsupported` with the result;
  - it leaves `out_freq_byte` and `out_div_sel` unchanged;
  - it does not change `out_pll_en`.
  A supported request clears `out_unsupported`.
- R7: With `in_chip_div`=1, `out_div_sel` is chosen from the pixel depth as follows:
  - depth 8 or 24 selects /8 (code 3);
  - depth 15 or 16 selects /4 (code 2);
  - depth 32 selects /2 (code 1);
  - any other depth selects /1 (code 0).
- R8: With `in_chip_div`=0, depth 24 selects /8 (code 3) and every other depth selects /1 (code 0).
- R9: `out_pll_en` is 0 from reset until the first supported result. From that result on it is 1.
- R10: A request accepted on edge N makes `in_ready` low after edge N and produces a single-cycle `out_done` after edge N+1, when `in_ready` is high again.
- R11: After reset the outputs are:
  - `out_freq_byte`, `out_div_sel`, `out_unsupported`, `out_pll_en` and `out_done` all 0;
  - `in_ready` 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Block can accept a request |
| in_freq | input | FREQ_W (16) | Requested pixel frequency, 10 kHz units |
| in_bpp | input | BPP_W (6) | Pixel depth in bits |
| in_chip_div | input | 1 | 1 when the graphics engine divides the pixel clock |
| out_done | output | 1 | One-cycle pulse marking a new result |
| out_freq_byte | output | 8 | {band code, divide count} |
| out_div_sel | output | 2 | Post-divider: 0=/1, 1=/2, 2=/4, 3=/8 |
| out_pll_en | output | 1 | PLL enable, set by the first supported result |
| out_unsupported | output | 1 | Last request fell outside every band |

## Verification
The assertions check the following on every cycle:
- the accept-then-done timing and the single-cycle `out_done` pulse;
- that an unsupported result holds the byte and the divider;
- that a supported result has the PLL enabled;
- that the band field agrees with the classifier;
- that at most one band matches;
- that the quotient of an in-band request fits in six bits.

The exact count values, the rounding direction at each half-step edge, the gaps between bands and the depth-to-divider mapping can only be shown by the bench's scenarios. The bench compares each result against a model built from the truncate-then-round definition.

// File: rtl/pll_calc_pkg.sv
package pll_calc_pkg;

  localparam int NUM_BANDS = 4;
  localparam int BAND_W    = $clog2(NUM_BANDS);
  localparam int COUNT_W   = 6;
  localparam int BYTE_W    = BAND_W + COUNT_W;

  typedef enum logic [1:0] {
    PDIV_1 = 2'd0,
    PDIV_2 = 2'd1,
    PDIV_4 = 2'd2,
    PDIV_8 = 2'd3
  } postdiv_e;

  // Band limits and step sizes, in 10 kHz units.
  function automatic int band_lo(input int b);
    case (b)
      0:       return 1625;
      1:       return 3250;
      2:       return 6500;
      default: return 13000;
    endcase
  endfunction

  function automatic int band_hi(input int b);
    case (b)
      0:       return 3200;
      1:       return 6400;
      2:       return 12800;
      default: return 25000;
    endcase
  endfunction

  function automatic int band_step(input int b);
    case (b)
      0:       return 25;
      1:       return 50;
      2:       return 100;
      default: return 200;
    endcase
  endfunction

endpackage

// File: rtl/pll_band_classify.sv
module pll_band_classify
  import pll_calc_pkg::*;
#(
  parameter int FREQ_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [FREQ_W-1:0] freq,
  output logic              in_band,
  output logic [BAND_W-1:0] band
);

  logic [NUM_BANDS-1:0] hit;

  for (genvar b = 0; b < NUM_BANDS; b++) begin : g_win
    localparam logic [FREQ_W-1:0] LO = FREQ_W'(band_lo(b));
    localparam logic [FREQ_W-1:0] HI = FREQ_W'(band_hi(b));
    assign hit[b] = (freq >= LO) && (freq <= HI);
  end

  always_comb begin
    band = '0;
    for (int b = 0; b < NUM_BANDS; b++) begin
      if (hit[b]) band = BAND_W'(b);
    end
  end

  assign in_band = |hit;

  // R6: band windows never overlap, so a request picks at most one band
  a_r6_band_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit));

endmodule

// File: rtl/pll_count_round.sv
module pll_count_round
  import pll_calc_pkg::*;
#(
  parameter int FREQ_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [FREQ_W-1:0]  freq,
  input  logic [BAND_W-1:0]  band,
  input  logic               in_band,
  output logic [COUNT_W-1:0] count
);

  localparam int EXT_W = FREQ_W + 1;
  localparam logic [EXT_W-1:0] CNT_MAX = EXT_W'((1 << COUNT_W) - 1);

  logic [EXT_W-1:0] quo [NUM_BANDS];

  // Round-half-up to the step, then take the step index above the band floor:
  // (freq - lo + (step - step/2)) / step.
  for (genvar b = 0; b < NUM_BANDS; b++) begin : g_band
    localparam int STEP_I = band_step(b);
    localparam logic [EXT_W-1:0] LO_W   = EXT_W'(band_lo(b));
    localparam logic [EXT_W-1:0] STEP_W = EXT_W'(STEP_I);
    localparam logic [EXT_W-1:0] BIAS_W = EXT_W'(STEP_I - STEP_I / 2);
    logic [EXT_W-1:0] shifted;
    assign shifted = {1'b0, freq} - LO_W + BIAS_W;
    assign quo[b]  = shifted / STEP_W;
  end

  assign count = quo[band][COUNT_W-1:0];

  // R1: for an in-band request the step index fits the six-bit count field
  a_r1_count_fits: assert property (@(posedge clk) disable iff (!rst_n)
    in_band |-> (quo[band] <= CNT_MAX));

endmodule

// File: rtl/pll_postdiv_sel.sv
module pll_postdiv_sel
  import pll_calc_pkg::*;
#(
  parameter int BPP_W = 6
) (
  input  logic [BPP_W-1:0] bpp,
  input  logic             chip_div,
  output postdiv_e         sel
);

  always_comb begin
    sel = PDIV_1;
    if (chip_div) begin
      case (bpp)
        BPP_W'(8), BPP_W'(24):  sel = PDIV_8;
        BPP_W'(15), BPP_W'(16): sel = PDIV_4;
        BPP_W'(32):             sel = PDIV_2;
        default:                sel = PDIV_1;
      endcase
    end else if (bpp == BPP_W'(24)) begin
      sel = PDIV_8;
    end
  end

endmodule

// File: rtl/pll_divcount_calc.sv
module pll_divcount_calc
  import pll_calc_pkg::*;
#(
  parameter int FREQ_W = 16,
  parameter int BPP_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [FREQ_W-1:0] in_freq,
  input  logic [BPP_W-1:0]  in_bpp,
  input  logic              in_chip_div,
  output logic              out_done,
  output logic [BYTE_W-1:0] out_freq_byte,
  output logic [1:0]        out_div_sel,
  output logic              out_pll_en,
  output logic              out_unsupported
);

  logic              busy;
  logic [FREQ_W-1:0] freq_q;
  logic [BPP_W-1:0]  bpp_q;
  logic              chip_div_q;
  logic              take;

  logic               hit_any;
  logic [BAND_W-1:0]  band_c;
  logic [COUNT_W-1:0] count_c;
  postdiv_e           div_c;

  assign in_ready = !busy;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      freq_q     <= '0;
      bpp_q      <= '0;
      chip_div_q <= 1'b0;
    end else if (take) begin
      busy       <= 1'b1;
      freq_q     <= in_freq;
      bpp_q      <= in_bpp;
      chip_div_q <= in_chip_div;
    end else begin
      busy       <= 1'b0;
    end
  end

  pll_band_classify #(.FREQ_W(FREQ_W)) u_cls (
    .clk     (clk),
    .rst_n   (rst_n),
    .freq    (freq_q),
    .in_band (hit_any),
    .band    (band_c)
  );

  pll_count_round #(.FREQ_W(FREQ_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .freq    (freq_q),
    .band    (band_c),
    .in_band (hit_any),
    .count   (count_c)
  );

  pll_postdiv_sel #(.BPP_W(BPP_W)) u_div (
    .bpp      (bpp_q),
    .chip_div (chip_div_q),
    .sel      (div_c)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_done        <= 1'b0;
      out_freq_byte   <= '0;
      out_div_sel     <= 2'd0;
      out_pll_en      <= 1'b0;
      out_unsupported <= 1'b0;
    end else begin
      out_done <= busy;
      if (busy) begin
        if (hit_any) begin
          out_freq_byte   <= {band_c, count_c};
          out_div_sel     <= div_c;
          out_pll_en      <= 1'b1;
          out_unsupported <= 1'b0;
        end else begin
          out_unsupported <= 1'b1;
        end
      end
    end
  end

  // R10: an accepted request stalls the input for a cycle, then completes
  a_r10_accept_done: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (!in_ready ##1 out_done));

  // R10: the completion marker lasts one cycle
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    out_done |=> !out_done);

  // R6: an out-of-band result keeps the previous settings
  a_r6_hold_settings: assert property (@(posedge clk) disable iff (!rst_n)
    (out_done && out_unsupported) |-> ($stable(out_freq_byte) && $stable(out_div_sel)));

  // R9: any supported result leaves the PLL enabled
  a_r9_pll_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    (out_done && !out_unsupported) |-> out_pll_en);

  // R1: the band field of a fresh supported result matches the classifier
  a_r1_band_field: assert property (@(posedge clk) disable iff (!rst_n)
    (out_done && !out_unsupported) |-> (out_freq_byte[BYTE_W-1:COUNT_W] == band_c));

endmodule

// File: tb/sim_pll_divcount_calc.sv
`timescale 1ns/1ps
module sim_pll_divcount_calc;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_freq = '0;
  logic [5:0]  in_bpp = '0;
  logic        in_chip_div = 1'b0;
  logic        out_done;
  logic [7:0]  out_freq_byte;
  logic [1:0]  out_div_sel;
  logic        out_pll_en;
  logic        out_unsupported;

  always #2 clk = ~clk;

  pll_divcount_calc u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_freq(in_freq), .in_bpp(in_bpp), .in_chip_div(in_chip_div),
    .out_done(out_done), .out_freq_byte(out_freq_byte), .out_div_sel(out_div_sel),
    .out_pll_en(out_pll_en), .out_unsupported(out_unsupported)
  );

  typedef struct {
    int fb;
    int dv;
    bit uns;
    bit pen;
    int req;
  } exp_t;

  exp_t exp_q[$];
  int   n_checks = 0;
  int   n_fails  = 0;
  int   last_fb  = 0;
  int   last_dv  = 0;
  bit   last_pen = 0;
  bit   finished = 0;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  // Reference model: truncate to step, round up at half step, per-band count formula.
  function automatic exp_t model(input int f, input int bpp, input bit cd);
    exp_t e;
    int lo[4]  = '{1625, 3250, 6500, 13000};
    int hi[4]  = '{3200, 6400, 12800, 25000};
    int stp[4] = '{25, 50, 100, 200};
    int band = -1;
    int r, num, cnt, dv;
    for (int b = 0; b < 4; b++) if (f >= lo[b] && f <= hi[b]) band = b;
    if (cd) begin
      if (bpp == 8 || bpp == 24) dv = 3;
      else if (bpp == 15 || bpp == 16) dv = 2;
      else if (bpp == 32) dv = 1;
      else dv = 0;
    end else begin
      dv = (bpp == 24) ? 3 : 0;
    end
    e.req = f;
    if (band < 0) begin
      e.fb = last_fb; e.dv = last_dv; e.uns = 1; e.pen = last_pen;
    end else begin
      r = (f / stp[band]) * stp[band];
      if (f - r >= stp[band] / 2) r += stp[band];
      case (band)
        0: num = 4 * r;
        1: num = 2 * r;
        2: num = r;
        default: num = r / 2;
      endcase
      cnt = (num - 6500) / 100;
      e.fb = band * 64 + cnt; e.dv = dv; e.uns = 0; e.pen = 1;
    end
    last_fb = e.fb; last_dv = e.dv; last_pen = e.pen;
    return e;
  endfunction

  // Monitor: pops expected items when the design marks a result.
  always @(negedge clk) begin
    if (rst_n && out_done && !finished) begin
      if (exp_q.size() == 0) begin
        chk(0, "R10 unexpected done", 1, 0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk(out_freq_byte == e.fb[7:0], $sformatf("R1/R2/R3/R4/R5 byte for req %0d", e.req), out_freq_byte, e.fb);
        chk(out_div_sel == e.dv[1:0], $sformatf("R7/R8 divider for req %0d", e.req), out_div_sel, e.dv);
        chk(out_unsupported == e.uns, $sformatf("R6 unsupported for req %0d", e.req), out_unsupported, e.uns);
        chk(out_pll_en == e.pen, $sformatf("R9 pll enable for req %0d", e.req), out_pll_en, e.pen);
      end
    end
  end

  task automatic send(input int f, input int bpp, input bit cd);
    exp_q.push_back(model(f, bpp, cd));
    @(negedge clk);
    chk(in_ready == 1'b1, "R10 ready while idle", in_ready, 1);
    in_valid = 1'b1; in_freq = 16'(f); in_bpp = 6'(bpp); in_chip_div = cd;
    @(negedge clk);
    chk(in_ready == 1'b0, "R10 ready low after accept", in_ready, 0);
    chk(out_done == 1'b0, "R10 no done one cycle after accept", out_done, 0);
    in_valid = 1'b0;
    @(negedge clk);
    chk(out_done == 1'b1, "R10 done two cycles after accept", out_done, 1);
    chk(in_ready == 1'b1, "R10 ready back with done", in_ready, 1);
  endtask

  // Valid held through the busy cycle: two acceptances, two results.
  task automatic send_held(input int f, input int bpp, input bit cd);
    exp_q.push_back(model(f, bpp, cd));
    exp_q.push_back(model(f, bpp, cd));
    @(negedge clk);
    in_valid = 1'b1; in_freq = 16'(f); in_bpp = 6'(bpp); in_chip_div = cd;
    @(negedge clk);
    @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    chk(out_done == 1'b1, "R10 second result under held valid", out_done, 1);
    @(negedge clk);
    chk(out_done == 1'b0, "R10 no extra result", out_done, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk(out_freq_byte == 8'd0, "R11 byte", out_freq_byte, 0);
    chk(out_div_sel == 2'd0, "R11 divider", out_div_sel, 0);
    chk(out_unsupported == 1'b0, "R11 unsupported", out_unsupported, 0);
    chk(out_pll_en == 1'b0, "R11 pll enable", out_pll_en, 0);
    chk(out_done == 1'b0, "R11 done", out_done, 0);
    chk(in_ready == 1'b1, "R11 ready", in_ready, 1);

    // R6/R9: unsupported before any supported request keeps PLL off
    send(0, 32, 1);
    // R1 band 0, R5 rounding both ways
    send(1625, 8, 1);
    send(2511, 16, 1);
    send(2513, 15, 1);
    send(3199, 32, 1);
    send(3200, 24, 0);
    // R2 band 1
    send(3250, 8, 0);
    send(4024, 16, 0);
    send(4025, 32, 1);
    send(6400, 4, 1);
    // R3 band 2
    send(6500, 24, 1);
    send(10049, 16, 1);
    send(10050, 8, 0);
    send(12800, 32, 0);
    // R4 band 3
    send(13000, 15, 1);
    send(20099, 24, 0);
    send(20100, 32, 1);
    send(24999, 8, 1);
    send(25000, 16, 1);
    // R6 gaps and edges: byte and divider held
    send(3210, 24, 1);
    send(1624, 8, 0);
    send(6450, 16, 1);
    send(12900, 32, 1);
    send(25001, 24, 0);
    // R6 cleared by a supported request
    send(8000, 32, 1);
    // R10 valid held across the busy cycle
    send_held(5000, 16, 1);

    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R10 all results produced", exp_q.size(), 0);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule